// File: doc/BRIEF.md
# Helicity-Window Sample Integrator

This block runs beside a fast detector digitiser and takes one ADC sample on every clock. It forms a running sum of all samples between an external start strobe and an external stop strobe, which bound one helicity window. It does not discriminate pulses, so overlapping pulses add in full. During the window it drives every sample out on a write port to an external circular capture memory, advancing a free-running address. It also counts discriminated detector hits and records, for each hit, how many samples have passed since the window opened.

Results live in two banks. When the window closes, the block freezes the finished bank's sum, hit count, first and last capture addresses and error flags, then swaps to the other bank. If that other bank is free, the block arms for the next start strobe on the very next cycle. The frozen bank is offered on a valid/ready summary port and its hit offsets are read by index. A readout-done pulse hands the bank back. From the window end until that pulse, new detector hits are discarded, so the hit list never grows beyond what the readout can drain.

Top module: `hwin_accum`

## Requirements
- R1: After reset the block is armed, not integrating, drives no capture write, and `rdValid` is low.
- R2: A start strobe is accepted only while `armed` is high. The window covers the samples from the start cycle up to, but not including, the cycle in which the stop strobe is seen. A stop strobe has no effect while no window is open, and a start strobe has no effect while the block is not armed.
- R3: Every window sample is driven on `capWrData` with `capWrEn` high at `capWrAddr`. The address advances by one per sample modulo 2^ADDR_W and carries on across windows. The frozen bank reports the window's first address in `rdStartPtr` and the next unwritten address in `rdEndPtr`.
- R4: The sum adds every window sample as an unsigned value. It saturates at 2^SUM_W-1, and saturation sets `rdSumOvf`.
- R5: One cycle after the stop strobe, the finished window is offered with `rdValid` high. Its fields stay unchanged until `readoutDone`.
- R6: One cycle after a window ends, `armed` is high if the other bank is free. Otherwise `armed` stays low until `readoutDone` releases that bank.
- R7: Each accepted hit increments `rdCount` and stores its offset from the window start, where the start cycle has offset 0. Only the first EVT_DEPTH offsets are stored, readable at `evtRdOff` one cycle after `evtRdIdx` is set. Any further hit still counts and sets `rdTrunc`.
- R8: From a window end until `readoutDone`, detector hits are ignored, including hits inside a new window, and they leave that window's `rdCount` at zero.
- R9: A window longer than 2^ADDR_W samples sets `rdWrapErr`.
- R10: A summary accepted with `rdValid` and `rdReady` both high drops `rdValid` on the next cycle. Frozen banks are offered oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | SAMPLE_W | Unsigned ADC sample |
| startStrobe | input | 1 | Window start trigger |
| stopStrobe | input | 1 | Window end trigger |
| eventHit | input | 1 | Discriminated detector hit in this sample |
| readoutDone | input | 1 | Releases the oldest frozen bank and ends hit suppression |
| rdReady | input | 1 | Accepts the offered summary |
| evtRdIdx | input | IDX_W | Hit-list index for readout |
| armed | output | 1 | Ready to accept a start strobe |
| integrating | output | 1 | A window is open |
| capWrEn | output | 1 | Capture memory write enable |
| capWrAddr | output | ADDR_W | Capture memory address |
| capWrData | output | SAMPLE_W | Capture memory data |
| rdValid | output | 1 | A frozen summary is offered |
| rdSum | output | SUM_W | Window sum |
| rdCount | output | CNT_W | Hits in the window |
| rdStartPtr | output | ADDR_W | First capture address |
| rdEndPtr | output | ADDR_W | Next capture address after the window |
| rdWrapErr | output | 1 | Capture memory wrapped in the window |
| rdSumOvf | output | 1 | Sum saturated |
| rdTrunc | output | 1 | Hit list overflowed |
| evtRdOff | output | ADDR_W | Stored hit offset, one cycle after index |

## Verification
The bench drives windows of a constant level, a ramp, full-scale samples and a run longer than the capture depth. These separate a correct unconditional sum from a sum that drops the start sample or adds the stop sample, and from a sum that wraps instead of saturating. It also tells a wrap error from a clean window. Hit patterns spaced every few samples land exactly on the list depth or run past it, which checks both the stored offsets and truncation. Two windows closed back to back without readout show that hits are suppressed, that arming is blocked while both banks are held, and that the banks come out oldest first.

// File: rtl/hwin_pkg.sv
package hwin_pkg;
  typedef struct packed {
    logic startAcc;
    logic inWin;
    logic evtOk;
    logic freeze;
    logic bank;
  } hwin_ctl_t;
endpackage

// File: rtl/hwin_ctrl.sv
module hwin_ctrl
  import hwin_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStrobe,
  input  logic      stopStrobe,
  input  logic      eventHit,
  input  logic      readoutDone,
  input  logic      rdReady,
  output hwin_ctl_t ctl,
  output logic      rdBank,
  output logic      armed,
  output logic      integrating,
  output logic      rdValid
);
  logic       integ;
  logic       active;
  logic [1:0] held;
  logic       taken;
  logic       suppress;
  logic       stopAcc;

  assign armed       = !integ && !held[active];
  assign integrating = integ;
  assign stopAcc     = integ && stopStrobe;
  assign rdValid     = held[rdBank] && !taken;

  always_comb begin
    ctl.startAcc = armed && startStrobe;
    ctl.inWin    = ctl.startAcc || (integ && !stopStrobe);
    ctl.evtOk    = ctl.inWin && eventHit && !suppress;
    ctl.freeze   = stopAcc;
    ctl.bank     = active;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      integ    <= 1'b0;
      active   <= 1'b0;
      held     <= 2'b00;
      taken    <= 1'b0;
      suppress <= 1'b0;
      rdBank   <= 1'b0;
    end else begin
      if (ctl.startAcc) integ <= 1'b1;
      if (rdValid && rdReady) taken <= 1'b1;
      if (readoutDone) begin
        suppress <= 1'b0;
        if (held[rdBank]) begin
          held[rdBank] <= 1'b0;
          rdBank       <= ~rdBank;
          taken        <= 1'b0;
        end
      end
      if (stopAcc) begin
        integ        <= 1'b0;
        held[active] <= 1'b1;
        active       <= ~active;
        suppress     <= 1'b1;
      end
    end
  end

  // R2: a start seen while idle and not armed leaves the block idle
  p_start_needs_arm_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startStrobe && !armed && !integ) |=> !integ);

  // R6: the block re-arms right after a window end when the other bank is free
  p_rearm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stopAcc && !held[!active]) |=> armed);

  // R10: an accepted summary is withdrawn on the next cycle
  p_taken_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady && !readoutDone) |=> !rdValid);
endmodule

// File: rtl/hwin_datapath.sv
module hwin_datapath
  import hwin_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int ADDR_W    = 24,
  parameter int SUM_W     = SAMPLE_W + ADDR_W,
  parameter int EVT_DEPTH = 256,
  localparam int CNT_W    = ADDR_W + 1,
  localparam int IDX_W    = (EVT_DEPTH > 1) ? $clog2(EVT_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  hwin_ctl_t           ctl,
  input  logic                rdBank,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [IDX_W-1:0]    evtRdIdx,
  output logic                capWrEn,
  output logic [ADDR_W-1:0]   capWrAddr,
  output logic [SAMPLE_W-1:0] capWrData,
  output logic [SUM_W-1:0]    rdSum,
  output logic [CNT_W-1:0]    rdCount,
  output logic [ADDR_W-1:0]   rdStartPtr,
  output logic [ADDR_W-1:0]   rdEndPtr,
  output logic                rdWrapErr,
  output logic                rdSumOvf,
  output logic                rdTrunc,
  output logic [ADDR_W-1:0]   evtRdOff
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(EVT_DEPTH);
  localparam logic [SUM_W-1:0] SUM_MAX = '1;

  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] offCnt;
  logic [SUM_W-1:0]  sumR   [2];
  logic [CNT_W-1:0]  cntR   [2];
  logic [ADDR_W-1:0] sPtrR  [2];
  logic [ADDR_W-1:0] ePtrR  [2];
  logic              wrapR  [2];
  logic              ovfR   [2];
  logic              truncR [2];
  logic [ADDR_W-1:0] evtMem [2][EVT_DEPTH];

  logic [SUM_W:0]    sumAdd;
  logic [CNT_W-1:0]  curCnt;
  logic [ADDR_W-1:0] curOff;

  always_comb begin
    sumAdd = {1'b0, sumR[ctl.bank]} + (SUM_W + 1)'(sampleIn);
    curCnt = ctl.startAcc ? '0 : cntR[ctl.bank];
    curOff = ctl.startAcc ? '0 : offCnt;
  end

  assign capWrEn   = ctl.inWin;
  assign capWrAddr = wrPtr;
  assign capWrData = sampleIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      offCnt <= '0;
      for (int b = 0; b < 2; b++) begin
        sumR[b]   <= '0;
        cntR[b]   <= '0;
        sPtrR[b]  <= '0;
        ePtrR[b]  <= '0;
        wrapR[b]  <= 1'b0;
        ovfR[b]   <= 1'b0;
        truncR[b] <= 1'b0;
      end
    end else begin
      if (ctl.inWin) begin
        wrPtr  <= wrPtr + 1'b1;
        offCnt <= curOff + 1'b1;
      end
      if (ctl.startAcc) begin
        sPtrR[ctl.bank]  <= wrPtr;
        sumR[ctl.bank]   <= SUM_W'(sampleIn);
        cntR[ctl.bank]   <= '0;
        wrapR[ctl.bank]  <= 1'b0;
        ovfR[ctl.bank]   <= 1'b0;
        truncR[ctl.bank] <= 1'b0;
      end else if (ctl.inWin) begin
        if (sumAdd[SUM_W]) begin
          sumR[ctl.bank] <= SUM_MAX;
          ovfR[ctl.bank] <= 1'b1;
        end else begin
          sumR[ctl.bank] <= sumAdd[SUM_W-1:0];
        end
        if (offCnt == '0) wrapR[ctl.bank] <= 1'b1;
      end
      if (ctl.evtOk) begin
        cntR[ctl.bank] <= curCnt + 1'b1;
        if (curCnt >= DEPTH_C) truncR[ctl.bank] <= 1'b1;
      end
      if (ctl.freeze) ePtrR[ctl.bank] <= wrPtr;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.evtOk && curCnt < DEPTH_C)
      evtMem[ctl.bank][curCnt[IDX_W-1:0]] <= curOff;
    evtRdOff <= evtMem[rdBank][evtRdIdx];
  end

  assign rdSum      = sumR[rdBank];
  assign rdCount    = cntR[rdBank];
  assign rdStartPtr = sPtrR[rdBank];
  assign rdEndPtr   = ePtrR[rdBank];
  assign rdWrapErr  = wrapR[rdBank];
  assign rdSumOvf   = ovfR[rdBank];
  assign rdTrunc    = truncR[rdBank];

  // R4: inside a window the running sum never shrinks
  p_sum_monotonic_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inWin && !ctl.startAcc) |=> sumR[$past(ctl.bank)] >= $past(sumR[ctl.bank]));

  // R9: passing the capture depth inside a window flags a wrap
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inWin && !ctl.startAcc && offCnt == '0) |=> wrapR[$past(ctl.bank)]);

  for (genvar g = 0; g < 2; g++) begin : g_bankChk
    // R7: truncation only once the count exceeds the list depth
    p_trunc_r7: assert property (@(posedge clk) disable iff (!rstN)
      truncR[g] |-> cntR[g] > DEPTH_C);
  end
endmodule

// File: rtl/hwin_accum.sv
module hwin_accum
  import hwin_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int ADDR_W    = 24,
  parameter int SUM_W     = SAMPLE_W + ADDR_W,
  parameter int EVT_DEPTH = 256,
  localparam int CNT_W    = ADDR_W + 1,
  localparam int IDX_W    = (EVT_DEPTH > 1) ? $clog2(EVT_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                startStrobe,
  input  logic                stopStrobe,
  input  logic                eventHit,
  input  logic                readoutDone,
  input  logic                rdReady,
  input  logic [IDX_W-1:0]    evtRdIdx,
  output logic                armed,
  output logic                integrating,
  output logic                capWrEn,
  output logic [ADDR_W-1:0]   capWrAddr,
  output logic [SAMPLE_W-1:0] capWrData,
  output logic                rdValid,
  output logic [SUM_W-1:0]    rdSum,
  output logic [CNT_W-1:0]    rdCount,
  output logic [ADDR_W-1:0]   rdStartPtr,
  output logic [ADDR_W-1:0]   rdEndPtr,
  output logic                rdWrapErr,
  output logic                rdSumOvf,
  output logic                rdTrunc,
  output logic [ADDR_W-1:0]   evtRdOff
);
  hwin_ctl_t ctl;
  logic      rdBank;

  hwin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .stopStrobe(stopStrobe),
    .eventHit(eventHit), .readoutDone(readoutDone), .rdReady(rdReady),
    .ctl(ctl), .rdBank(rdBank), .armed(armed), .integrating(integrating),
    .rdValid(rdValid)
  );

  hwin_datapath #(
    .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .SUM_W(SUM_W), .EVT_DEPTH(EVT_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdBank(rdBank), .sampleIn(sampleIn),
    .evtRdIdx(evtRdIdx), .capWrEn(capWrEn), .capWrAddr(capWrAddr),
    .capWrData(capWrData), .rdSum(rdSum), .rdCount(rdCount),
    .rdStartPtr(rdStartPtr), .rdEndPtr(rdEndPtr), .rdWrapErr(rdWrapErr),
    .rdSumOvf(rdSumOvf), .rdTrunc(rdTrunc), .evtRdOff(evtRdOff)
  );

  // R5: an offered summary holds still until the bank is released
  p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !readoutDone) |=> ($stable(rdSum) && $stable(rdCount) && $stable(rdEndPtr)));
endmodule

// File: tb/hwin_accum_bench.sv
module hwin_accum_bench;
  localparam int SW = 12, AW = 6, SUMW = 14, DEPTH = 4;
  localparam int CW = AW + 1, IW = 2, MEMN = 64, SMAX = 16383;

  typedef struct {
    int sum; int cnt; int sPtr; int ePtr; bit wrap; bit ovf; bit trunc; int offs[DEPTH];
  } exp_t;

  logic clk = 0, rstN = 0;
  logic [SW-1:0] sampleIn = '0;
  logic startStrobe = 0, stopStrobe = 0, eventHit = 0, readoutDone = 0, rdReady = 0;
  logic [IW-1:0] evtRdIdx = '0;
  logic armed, integrating, capWrEn, rdValid, rdWrapErr, rdSumOvf, rdTrunc;
  logic [AW-1:0] capWrAddr, rdStartPtr, rdEndPtr, evtRdOff;
  logic [SW-1:0] capWrData;
  logic [SUMW-1:0] rdSum;
  logic [CW-1:0] rdCount;

  int checks = 0, errors = 0, ptr = 0, cycles = 0;
  exp_t expQ[$];

  always #4 clk = ~clk;

  hwin_accum #(.SAMPLE_W(SW), .ADDR_W(AW), .SUM_W(SUMW), .EVT_DEPTH(DEPTH)) u_hwin_accum (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .startStrobe(startStrobe),
    .stopStrobe(stopStrobe), .eventHit(eventHit), .readoutDone(readoutDone),
    .rdReady(rdReady), .evtRdIdx(evtRdIdx), .armed(armed), .integrating(integrating),
    .capWrEn(capWrEn), .capWrAddr(capWrAddr), .capWrData(capWrData), .rdValid(rdValid),
    .rdSum(rdSum), .rdCount(rdCount), .rdStartPtr(rdStartPtr), .rdEndPtr(rdEndPtr),
    .rdWrapErr(rdWrapErr), .rdSumOvf(rdSumOvf), .rdTrunc(rdTrunc), .evtRdOff(evtRdOff)
  );

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
        finishRun();
      end
    end
  end

  function automatic int sampleOf(input int kind, input int i);
    case (kind)
      0: return 100;
      1: return i * 7;
      2: return 4095;
      3: return 1;
      default: return 5;
    endcase
  endfunction

  // Driver: plays one window and pushes the expected summary on the scoreboard
  task automatic runWindow(input int len, input int kind, input int evtEvery,
                           input bit suppressed, input bit expArmed);
    exp_t e;
    int total = 0, capBad = 0;
    e.cnt = 0; e.sPtr = ptr;
    foreach (e.offs[k]) e.offs[k] = 0;
    for (int i = 0; i < len; i++) begin
      startStrobe = (i == 0);
      sampleIn = SW'(sampleOf(kind, i));
      eventHit = (evtEvery > 0) && (i % evtEvery == 0);
      total += sampleOf(kind, i);
      if (eventHit && !suppressed) begin
        if (e.cnt < DEPTH) e.offs[e.cnt] = i;
        e.cnt++;
      end
      #1;
      if (!(capWrEn && capWrAddr == AW'((ptr + i) % MEMN) && capWrData == sampleIn)) capBad++;
      @(negedge clk);
      if (i == 1) check("R2", "integrating mid window", integrating, 1);
    end
    check("R3", "capture write mismatches", capBad, 0);
    startStrobe = 0; stopStrobe = 1; sampleIn = SW'(999); eventHit = 1;
    @(negedge clk);
    stopStrobe = 0; eventHit = 0;
    check("R6", "armed after window end", armed, int'(expArmed));
    ptr = (ptr + len) % MEMN;
    e.ePtr = ptr;
    e.sum = (total > SMAX) ? SMAX : total;
    e.ovf = total > SMAX;
    e.wrap = len > MEMN;
    e.trunc = e.cnt > DEPTH;
    expQ.push_back(e);
  endtask

  // Monitor: pops the oldest expectation and compares the offered bank
  task automatic readOne();
    exp_t e;
    int waitN = 0;
    while (!rdValid && waitN < 50) begin @(negedge clk); waitN++; end
    check("R5", "rdValid offered", rdValid, 1);
    e = expQ.pop_front();
    check("R4", "sum", int'(rdSum), e.sum);
    check("R4", "sum overflow flag", rdSumOvf, int'(e.ovf));
    check("R7", "event count", int'(rdCount), e.cnt);
    check("R7", "truncation flag", rdTrunc, int'(e.trunc));
    check("R3", "start pointer", int'(rdStartPtr), e.sPtr);
    check("R3", "end pointer", int'(rdEndPtr), e.ePtr);
    check("R9", "wrap flag", rdWrapErr, int'(e.wrap));
    rdReady = 1;
    @(negedge clk);
    rdReady = 0;
    check("R10", "rdValid after accept", rdValid, 0);
    for (int k = 0; k < DEPTH && k < e.cnt; k++) begin
      evtRdIdx = IW'(k);
      @(negedge clk);
      check("R7", $sformatf("offset %0d", k), int'(evtRdOff), e.offs[k]);
    end
    readoutDone = 1;
    @(negedge clk);
    readoutDone = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1", "armed after reset", armed, 1);
    check("R1", "integrating after reset", integrating, 0);
    check("R1", "rdValid after reset", rdValid, 0);
    check("R1", "capWrEn after reset", capWrEn, 0);
    stopStrobe = 1; @(negedge clk); stopStrobe = 0; @(negedge clk);
    check("R2", "stop while idle ignored", rdValid, 0);

    runWindow(10, 0, 3, 0, 1); readOne();   // R7 list exactly full
    runWindow(12, 1, 2, 0, 1); readOne();   // R7 truncation, ramp sum
    runWindow(5, 2, 0, 0, 1);  readOne();   // R4 saturation
    runWindow(70, 3, 0, 0, 1); readOne();   // R9 wrap

    // R8: two windows without readout in between
    runWindow(8, 4, 4, 0, 1);
    runWindow(6, 1, 1, 1, 0);
    startStrobe = 1; @(negedge clk); startStrobe = 0;
    check("R2", "start ignored while not armed", integrating, 0);
    check("R6", "still not armed with both banks held", armed, 0);
    readOne();
    check("R6", "armed after bank released", armed, 1);
    readOne();
    check("R10", "no summary left", rdValid, 0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule